// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Driver Register

This block takes a serial bit stream and turns it into 32 parallel switch commands. Bits enter a 32-stage shift register on every falling edge of the shift clock. A level-sensitive output latch sits behind the shift register. While the load control is high the latch follows the shift register; while it is low the latch keeps its contents. This lets a new frame be shifted in while the outputs keep showing the previous one.

The latch contents then pass through a combinational stage that applies a polarity control and a blanking control. The result is 32 drive bits, where 1 means the corresponding output switch is sinking current. The last shift stage is also brought out as a serial output, so several devices can be chained on one data line.

A build parameter picks the shift direction. In one direction bits enter at stage 1 and leave at stage 32. In the other they enter at stage 32 and leave at stage 1. An active-low asynchronous reset clears both the shift register and the latch.

Top module: `osr_driver_top`

## Requirements
- R1: With `DIR = DIR_UP`, each falling edge of `shift_clk` moves every stage k to stage k+1 and loads `ser_in` into stage 1. Stage k drives `drive_on[k-1]`.
- R2: With `DIR = DIR_DOWN`, each falling edge of `shift_clk` moves every stage k to stage k-1 and loads `ser_in` into stage 32. `ser_out` is taken from stage 1.
- R3: `ser_out` always equals the current value of the last stage in the shift direction. With `DIR_UP` the last stage is stage 32.
- R4: While `load_en` is 1, the latch is transparent and takes on the shift register contents, including any change caused by a shift edge.
- R5: While `load_en` is 0, the latch holds its value even as the shift register keeps moving.
- R6: Shifting and `ser_out` are unaffected by `load_en`, `blank_n` and `out_pol`.
- R7: When `blank_n` = 0 and `out_pol` = 0, all 32 `drive_on` bits are 1, whatever the latch holds.
- R8: When `blank_n` = 0 and `out_pol` = 1, all 32 `drive_on` bits are 0.
- R9: When `blank_n` = 1 and `out_pol` = 1, `drive_on[i]` equals latch bit i.
- R10: When `blank_n` = 1 and `out_pol` = 0, `drive_on[i]` is the inverse of latch bit i.
- R11: While `rst_n` is 0, the shift register and the latch are cleared to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; the register advances on its falling edge |
| rst_n | input | 1 | Active-low asynchronous clear of the shift register and the latch |
| ser_in | input | 1 | Serial data input |
| load_en | input | 1 | Latch transparent when 1, holding when 0 |
| blank_n | input | 1 | 0 forces all outputs to a level set by `out_pol` |
| out_pol | input | 1 | 1 passes latch bits as they are, 0 inverts them |
| drive_on | output | 32 | Conditioned output commands; 1 means the switch is sinking |
| ser_out | output | 1 | Last shift stage, used for cascading |

## Verification
A wrong shift register stage shows up on `ser_out` only after it has moved to the end of the chain, which takes up to 32 falling edges. It shows up on `drive_on` as soon as the latch is transparent. A stuck or leaky latch shows at once on `drive_on` whenever blanking is released, but only if the bench shifts new data while `load_en` is low and then compares. For this reason the bench runs long hold phases followed by transparent phases, and drives two instances, one per direction, in lockstep against independent models. A fault in the blanking and polarity decode is visible in the same cycle on every output bit.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    MODE_ALL_ON  = 2'd0,
    MODE_ALL_OFF = 2'd1,
    MODE_INVERT  = 2'd2,
    MODE_TRUE    = 2'd3
  } drive_mode_e;
endpackage

// File: rtl/osr_shift.sv
module osr_shift #(
  parameter int            N   = 32,
  parameter osr_pkg::dir_e DIR = osr_pkg::DIR_UP
) (
  input  logic         shift_clk,
  input  logic         rst_n,
  input  logic         ser_in,
  output logic [N-1:0] stages,
  output logic         ser_out
);
  localparam int LAST = N - 1;

  generate
    if (DIR == osr_pkg::DIR_UP) begin : g_up
      always_ff @(negedge shift_clk or negedge rst_n) begin
        if (!rst_n) stages <= '0;
        else        stages <= {stages[LAST-1:0], ser_in};
      end
      assign ser_out = stages[LAST];

      AST_SHIFT_UP: assert property (@(negedge shift_clk) disable iff (!rst_n)
        1'b1 |=> stages[LAST:1] == $past(stages[LAST-1:0])); // R1
      AST_ENTRY_UP: assert property (@(negedge shift_clk) disable iff (!rst_n)
        1'b1 |=> stages[0] == $past(ser_in)); // R1
    end else begin : g_down
      always_ff @(negedge shift_clk or negedge rst_n) begin
        if (!rst_n) stages <= '0;
        else        stages <= {ser_in, stages[LAST:1]};
      end
      assign ser_out = stages[0];

      AST_SHIFT_DOWN: assert property (@(negedge shift_clk) disable iff (!rst_n)
        1'b1 |=> stages[LAST-1:0] == $past(stages[LAST:1])); // R2
      AST_ENTRY_DOWN: assert property (@(negedge shift_clk) disable iff (!rst_n)
        1'b1 |=> stages[LAST] == $past(ser_in)); // R2
    end
  endgenerate
endmodule

// File: rtl/osr_latch.sv
module osr_latch #(
  parameter int N = 32
) (
  input  logic         shift_clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_latch begin
    if (!rst_n)       q = '0;
    else if (load_en) q = d;
  end

  AST_LATCH_FOLLOW: assert property (@(negedge shift_clk) disable iff (!rst_n)
    load_en |-> q == d); // R4
  AST_LATCH_HOLD: assert property (@(negedge shift_clk) disable iff (!rst_n)
    (!load_en && $past(!load_en)) |-> q == $past(q)); // R5
endmodule

// File: rtl/osr_condition.sv
module osr_condition #(
  parameter int N = 32
) (
  input  logic         shift_clk,
  input  logic         rst_n,
  input  logic [N-1:0] held,
  input  logic         blank_n,
  input  logic         out_pol,
  output logic [N-1:0] drive_on
);
  import osr_pkg::*;

  drive_mode_e mode;

  always_comb begin
    unique case ({blank_n, out_pol})
      2'b00:   mode = MODE_ALL_ON;
      2'b01:   mode = MODE_ALL_OFF;
      2'b10:   mode = MODE_INVERT;
      default: mode = MODE_TRUE;
    endcase
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign drive_on[g] = (mode == MODE_ALL_ON)
                       | ((mode == MODE_TRUE)   &  held[g])
                       | ((mode == MODE_INVERT) & ~held[g]);
  end

  AST_ALL_ON: assert property (@(negedge shift_clk) disable iff (!rst_n)
    (!blank_n && !out_pol) |-> drive_on == {N{1'b1}}); // R7
  AST_ALL_OFF: assert property (@(negedge shift_clk) disable iff (!rst_n)
    (!blank_n && out_pol) |-> drive_on == '0); // R8
  AST_PASS: assert property (@(negedge shift_clk) disable iff (!rst_n)
    (blank_n && out_pol) |-> drive_on == held); // R9
  AST_INVERT: assert property (@(negedge shift_clk) disable iff (!rst_n)
    (blank_n && !out_pol) |-> drive_on == ~held); // R10
endmodule

// File: rtl/osr_driver_top.sv
module osr_driver_top #(
  parameter int            N   = 32,
  parameter osr_pkg::dir_e DIR = osr_pkg::DIR_UP
) (
  input  logic         shift_clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         load_en,
  input  logic         blank_n,
  input  logic         out_pol,
  output logic [N-1:0] drive_on,
  output logic         ser_out
);
  logic [N-1:0] sr_q;
  logic [N-1:0] lat_q;

  osr_shift #(.N(N), .DIR(DIR)) u_shift (
    .shift_clk (shift_clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .stages    (sr_q),
    .ser_out   (ser_out)
  );

  osr_latch #(.N(N)) u_latch (
    .shift_clk (shift_clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .d         (sr_q),
    .q         (lat_q)
  );

  osr_condition #(.N(N)) u_cond (
    .shift_clk (shift_clk),
    .rst_n     (rst_n),
    .held      (lat_q),
    .blank_n   (blank_n),
    .out_pol   (out_pol),
    .drive_on  (drive_on)
  );

  AST_SEROUT_TRACK: assert property (@(negedge shift_clk) disable iff (!rst_n)
    1'b1 |=> ser_out == (DIR == osr_pkg::DIR_UP ? $past(sr_q[N-2]) : $past(sr_q[1]))); // R3
endmodule

// File: tb/tb_osr_driver_top.sv
`timescale 1ns/100ps
module tb_osr_driver_top;
  localparam int N = 32;

  logic         shift_clk = 1'b1;
  logic         rst_n     = 1'b0;
  logic         ser_in    = 1'b0;
  logic         load_en   = 1'b0;
  logic         blank_n   = 1'b1;
  logic         out_pol   = 1'b1;
  logic [N-1:0] drv_f, drv_r;
  logic         so_f, so_r;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [N-1:0] m_sr_f = '0, m_sr_r = '0, m_lat_f = '0, m_lat_r = '0;

  always #2 shift_clk = ~shift_clk;

  osr_driver_top #(.N(N), .DIR(osr_pkg::DIR_UP)) dut (
    .shift_clk(shift_clk), .rst_n(rst_n), .ser_in(ser_in), .load_en(load_en),
    .blank_n(blank_n), .out_pol(out_pol), .drive_on(drv_f), .ser_out(so_f));

  osr_driver_top #(.N(N), .DIR(osr_pkg::DIR_DOWN)) dut_rev (
    .shift_clk(shift_clk), .rst_n(rst_n), .ser_in(ser_in), .load_en(load_en),
    .blank_n(blank_n), .out_pol(out_pol), .drive_on(drv_r), .ser_out(so_r));

  // reference model of the shift chains and latches
  always @(negedge shift_clk) begin
    if (!rst_n) begin
      m_sr_f = '0; m_sr_r = '0; m_lat_f = '0; m_lat_r = '0;
    end else begin
      m_sr_f = {m_sr_f[N-2:0], ser_in};
      m_sr_r = {ser_in, m_sr_r[N-1:1]};
      if (load_en) begin
        m_lat_f = m_sr_f;
        m_lat_r = m_sr_r;
      end
    end
  end

  function automatic logic [N-1:0] exp_drive(logic [N-1:0] lat, logic bn, logic pl);
    if (!bn) return pl ? '0 : '1;
    return pl ? lat : ~lat;
  endfunction

  function automatic string mode_tag(logic bn, logic pl);
    if (!bn) return pl ? "R8" : "R7";
    return pl ? "R9" : "R10";
  endfunction

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(string tg_out, string tg_ser);
    chk(tg_out, drv_f, exp_drive(m_lat_f, blank_n, out_pol));
    chk({tg_out, "/R2"}, drv_r, exp_drive(m_lat_r, blank_n, out_pol));
    chk(tg_ser, {{(N-1){1'b0}}, so_f}, {{(N-1){1'b0}}, m_sr_f[N-1]});
    chk("R2", {{(N-1){1'b0}}, so_r}, {{(N-1){1'b0}}, m_sr_r[0]});
  endtask

  // drive just after a rising edge, check just after the following falling edge
  task automatic step(logic d, logic le, logic bn, logic pl, string tg_out, string tg_ser);
    @(posedge shift_clk);
    #1;
    ser_in = d; load_en = le; blank_n = bn; out_pol = pl;
    if (le && rst_n) begin
      m_lat_f = m_sr_f;
      m_lat_r = m_sr_r;
    end
    #2;
    check_all(tg_out, tg_ser);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [N-1:0] pat;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    pat  = 32'hA5C3_0F96;

    // R11: reset state, pass and invert views of a cleared latch
    step(1'b1, 1'b1, 1'b1, 1'b1, "R11", "R11");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R11", "R11");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R11", "R11");
    @(posedge shift_clk); #1; rst_n = 1'b1;

    // R5: shift a frame while the latch holds, outputs stay cleared
    for (int i = 0; i < N; i++) step(pat[N-1-i], 1'b0, 1'b1, 1'b1, "R5", "R3");
    chk("R5", drv_f, '0);
    // R4: opening the latch shows the frame, R1: mapping of stages to outputs
    step(1'b0, 1'b1, 1'b1, 1'b1, "R4", "R3");
    chk("R1", drv_f, {pat[N-2:0], 1'b0});
    // R6: keep shifting under blanking and polarity changes
    for (int i = 0; i < 40; i++)
      step(i[0] ^ i[2], i[1], i[3], i[0], "R6", "R6");
    // R7/R8 directed with full latch
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7", "R3");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R8", "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R10", "R3");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R9", "R3");

    // constrained random: long hold phases, then transparent phases
    for (int blk = 0; blk < 60; blk++) begin
      int len;
      logic le_b;
      len  = 1 + ($urandom % 48);
      le_b = ($urandom % 3) == 0;
      for (int i = 0; i < len; i++) begin
        logic bn, pl;
        bn = ($urandom % 5) != 0;
        pl = $urandom % 2;
        step($urandom % 2, le_b, bn, pl, mode_tag(bn, pl), "R3");
      end
    end

    // R11: asynchronous clear in the middle of a cycle
    step(1'b1, 1'b1, 1'b1, 1'b1, "R9", "R3");
    @(posedge shift_clk); #1;
    rst_n = 1'b0;
    m_sr_f = '0; m_sr_r = '0; m_lat_f = '0; m_lat_r = '0;
    #0.5;
    check_all("R11", "R11");
    @(posedge shift_clk); #1; rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "R4", "R3");

    finish_run();
  end
endmodule